// File: doc/BRIEF.md
# Debug Register-Access Bridge to a CPU Debug Port

This block lets a debug interconnect that only speaks 16-bit register reads and writes reach the 32-bit registers of a processor core. Requests come in on a valid/ready channel with a 16-bit register address. Addresses from `WIN_BASE` (0x0200) upward form a window in which every 32-bit core register occupies two neighbouring 16-bit slots. The first 32 register pairs reach the general-purpose registers. The pairs after them reach the special-purpose registers. Each accepted request produces one response on a second valid/ready channel.

A read of either half runs its own bus cycle on the core's debug port and returns the selected 16 bits. Writes are split in two. A write to the lower half only loads a staging register. A write to the upper half issues a single 32-bit write cycle that joins the new upper half with the staged lower half, so the core register changes in one step. Addresses below the window, or past its last register, get an error response and cause no bus cycle.

Only one debug-port cycle is in flight at a time. The bridge holds the address, direction and write data steady until the core acknowledges, and it takes no new request until the response has been delivered.

Top module: `cdb_bridge`

## Requirements
- R1: A request whose address is below 0x0200, or at or above 0x0200 + 2*(GPR_COUNT+SPR_COUNT), gets a response with `rsp_error`=1 and `rsp_rdata`=0. It starts no debug-port cycle and leaves the staging register unchanged.
- R2: Inside the window, index = (addr-0x0200)>>1. An index below GPR_COUNT (32) drives `du_addr` = GPR_CORE_BASE (0x0400) + index. Any other index drives `du_addr` = index - GPR_COUNT.
- R3: A read drives `du_we`=0. Address bit 0 = 0 returns `du_rdata[15:0]` and bit 0 = 1 returns `du_rdata[31:16]`, with `rsp_error`=0. Each half costs exactly one debug-port cycle.
- R4: A write with address bit 0 = 0 stores `req_wdata` in the staging register and returns a success response with `rsp_rdata`=0. It issues no debug-port cycle.
- R5: A write with address bit 0 = 1 issues one debug-port cycle with `du_we`=1 and `du_wdata` = {req_wdata, staged lower half}, then returns a success response with `rsp_rdata`=0.
- R6: While `du_stb` is high and `du_ack` is low, `du_addr`, `du_we` and `du_wdata` do not change, and `du_stb` stays high.
- R7: Every accepted request yields exactly one response. While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_error` and `rsp_rdata` hold their values.
- R8: `req_ready` is high only when no debug-port cycle is open, no response is pending, and `rsp_ready` is high.
- R9: Reset clears the staging register to 0.
- R10: After reset `rsp_valid`=0 and `du_stb`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | 16-bit debug register address |
| req_wdata | input | 16 | Write data for one half |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken on this edge when valid |
| rsp_error | output | 1 | Address was outside the mapped window |
| rsp_rdata | output | 16 | Read data; 0 for writes and errors |
| du_stb | output | 1 | Debug-port cycle open |
| du_we | output | 1 | Debug-port write enable |
| du_addr | output | 16 | Debug-port core register address |
| du_wdata | output | 32 | Debug-port write data |
| du_rdata | input | 32 | Debug-port read data |
| du_ack | input | 1 | Debug-port cycle done |

## Verification
A vector table walks reads of both halves across the window. The entries include general-purpose register 0, register 31, the first special-purpose register and the last mapped one, so any mistake in the index-to-core-address split or in half selection shows up in the returned data and in the recorded core address. Addresses just under the base, one past the top, zero and 0xFFFF separate a correct window decode from an off-by-one. A lower-then-upper write pair followed by readback, an upper write after an out-of-window lower write, and a lone lower write that must not reach the core together tell correct staging apart from early or leaked writes. Directed runs use a slow acknowledge and a stalled response consumer to expose lost holds, and a reset before an upper-only write to expose an uncleared staging register.

// File: rtl/cdb_pkg.sv
// Package: shared types for the debug register-access bridge.
// Assumes a 16-bit debug register address and a 32-bit core register.
package cdb_pkg;

    localparam int HALF_W = 16;
    localparam int WORD_W = 32;

    // Result of decoding one debug register address.
    typedef struct packed {
        logic              hit;       // address lies in the mapped window
        logic              upper;     // selects bits [31:16]
        logic [HALF_W-1:0] core_addr; // debug-port register address
    } dec_t;

endpackage

// File: rtl/cdb_decode.sv
// Module: cdb_decode
// Maps a 16-bit debug address to a core register address and a half select.
// The window starts at WIN_BASE. Each register takes two slots: the first
// GPR_COUNT registers map to GPR_CORE_BASE+index and the rest map to
// index-GPR_COUNT. Purely combinational.
module cdb_decode
    import cdb_pkg::*;
#(
    parameter logic [15:0] WIN_BASE      = 16'h0200,
    parameter int          GPR_COUNT     = 32,
    parameter int          SPR_COUNT     = 2048,
    parameter logic [15:0] GPR_CORE_BASE = 16'h0400
) (
    input  logic [15:0] addr,
    output dec_t        dec
);
    localparam int          TOTAL   = GPR_COUNT + SPR_COUNT;
    localparam logic [15:0] TOTAL_V = 16'(TOTAL);
    localparam logic [15:0] GPR_V   = 16'(GPR_COUNT);

    logic [15:0] offset;
    logic [15:0] index;
    logic        above;

    // Offset from the window base and the register index it selects.
    always_comb begin
        offset = addr - WIN_BASE;
        index  = {1'b0, offset[15:1]};
        above  = (addr >= WIN_BASE);
    end

    // Window hit, half select and core address translation.
    generate
        if (SPR_COUNT == 0) begin : g_gpr_only
            always_comb begin
                dec.hit       = above && (index < TOTAL_V);
                dec.upper     = addr[0];
                dec.core_addr = GPR_CORE_BASE + index;
            end
        end else begin : g_gpr_spr
            always_comb begin
                dec.hit       = above && (index < TOTAL_V);
                dec.upper     = addr[0];
                dec.core_addr = (index < GPR_V) ? (GPR_CORE_BASE + index)
                                                : (index - GPR_V);
            end
        end
    endgenerate

endmodule

// File: rtl/cdb_stage.sv
// Module: cdb_stage
// Holds the lower half of a pending 32-bit write until the upper half comes.
// Assumes load is a single-cycle strobe from the request handshake.
module cdb_stage #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);
    // Capture the lower half on load and clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= din;
        end
    end

endmodule

// File: rtl/cdb_du_master.sv
// Module: cdb_du_master
// Runs one debug-port cycle at a time. Address, direction and data are held
// until du_ack arrives. Assumes start only comes while no cycle is open.
module cdb_du_master #(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            start_we,
    input  logic            start_upper,
    input  logic [AW-1:0]   start_addr,
    input  logic [DW-1:0]   start_wdata,
    output logic            du_stb,
    output logic            du_we,
    output logic [AW-1:0]   du_addr,
    output logic [DW-1:0]   du_wdata,
    input  logic [DW-1:0]   du_rdata,
    input  logic            du_ack,
    output logic            done,
    output logic [DW/2-1:0] done_data
);
    localparam int HW = DW / 2;

    logic upper_q;

    // Open a cycle on start and close it on the core's acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            du_stb   <= 1'b0;
            du_we    <= 1'b0;
            du_addr  <= '0;
            du_wdata <= '0;
            upper_q  <= 1'b0;
        end else if (start) begin
            du_stb   <= 1'b1;
            du_we    <= start_we;
            du_addr  <= start_addr;
            du_wdata <= start_wdata;
            upper_q  <= start_upper;
        end else if (du_stb && du_ack) begin
            du_stb   <= 1'b0;
        end
    end

    // Completion strobe and the selected half of the read data.
    always_comb begin
        done = du_stb && du_ack;
        if (du_we) begin
            done_data = '0;
        end else if (upper_q) begin
            done_data = du_rdata[DW-1:HW];
        end else begin
            done_data = du_rdata[HW-1:0];
        end
    end

endmodule

// File: rtl/cdb_rsp.sv
// Module: cdb_rsp
// Response register with a valid/ready output. Assumes load never comes
// while a response is still pending.
module cdb_rsp #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         load_err,
    input  logic [W-1:0] load_data,
    output logic         rsp_valid,
    input  logic         rsp_ready,
    output logic         rsp_error,
    output logic [W-1:0] rsp_rdata
);
    // Set on load and clear once the consumer takes the response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_error <= 1'b0;
            rsp_rdata <= '0;
        end else if (load) begin
            rsp_valid <= 1'b1;
            rsp_error <= load_err;
            rsp_rdata <= load_data;
        end else if (rsp_valid && rsp_ready) begin
            rsp_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/cdb_bridge.sv
// Module: cdb_bridge (top)
// Turns 16-bit debug register requests into 32-bit debug-port cycles.
// Reads of either half run their own cycle. A lower-half write is staged,
// and an upper-half write commits the full word. Out-of-window addresses
// are answered with an error. One request is in flight at a time.
module cdb_bridge
    import cdb_pkg::*;
#(
    parameter logic [15:0] WIN_BASE      = 16'h0200,
    parameter int          GPR_COUNT     = 32,
    parameter int          SPR_COUNT     = 2048,
    parameter logic [15:0] GPR_CORE_BASE = 16'h0400
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic        req_write,
    input  logic [15:0] req_addr,
    input  logic [15:0] req_wdata,
    output logic        rsp_valid,
    input  logic        rsp_ready,
    output logic        rsp_error,
    output logic [15:0] rsp_rdata,
    output logic        du_stb,
    output logic        du_we,
    output logic [15:0] du_addr,
    output logic [31:0] du_wdata,
    input  logic [31:0] du_rdata,
    input  logic        du_ack
);
    dec_t              dec;
    logic              accept;
    logic              use_bus;
    logic              stage_load;
    logic              bus_start;
    logic              direct_rsp;
    logic [HALF_W-1:0] staged;
    logic              bus_done;
    logic [HALF_W-1:0] bus_data;
    logic              rsp_load;
    logic              rsp_load_err;
    logic [HALF_W-1:0] rsp_load_data;

    cdb_decode #(
        .WIN_BASE      (WIN_BASE),
        .GPR_COUNT     (GPR_COUNT),
        .SPR_COUNT     (SPR_COUNT),
        .GPR_CORE_BASE (GPR_CORE_BASE)
    ) u_decode (
        .addr (req_addr),
        .dec  (dec)
    );

    // Request handshake and the routing of the accepted request.
    always_comb begin
        req_ready  = !du_stb && !rsp_valid && rsp_ready;
        accept     = req_valid && req_ready;
        use_bus    = dec.hit && (!req_write || dec.upper);
        stage_load = accept && dec.hit && req_write && !dec.upper;
        bus_start  = accept && use_bus;
        direct_rsp = accept && !use_bus;
    end

    cdb_stage #(.W(HALF_W)) u_stage (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (stage_load),
        .din   (req_wdata),
        .q     (staged)
    );

    cdb_du_master #(.AW(HALF_W), .DW(WORD_W)) u_master (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (bus_start),
        .start_we    (req_write),
        .start_upper (dec.upper),
        .start_addr  (dec.core_addr),
        .start_wdata ({req_wdata, staged}),
        .du_stb      (du_stb),
        .du_we       (du_we),
        .du_addr     (du_addr),
        .du_wdata    (du_wdata),
        .du_rdata    (du_rdata),
        .du_ack      (du_ack),
        .done        (bus_done),
        .done_data   (bus_data)
    );

    // Response source: immediate for errors and staged writes, else bus result.
    always_comb begin
        rsp_load      = direct_rsp || bus_done;
        rsp_load_err  = direct_rsp && !dec.hit;
        rsp_load_data = bus_done ? bus_data : '0;
    end

    cdb_rsp #(.W(HALF_W)) u_rsp (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (rsp_load),
        .load_err  (rsp_load_err),
        .load_data (rsp_load_data),
        .rsp_valid (rsp_valid),
        .rsp_ready (rsp_ready),
        .rsp_error (rsp_error),
        .rsp_rdata (rsp_rdata)
    );

endmodule

// File: rtl/cdb_checker.sv
// Module: cdb_checker
// Protocol properties of cdb_bridge, attached by bind.
module cdb_checker #(
    parameter logic [15:0] WIN_BASE  = 16'h0200,
    parameter int          GPR_COUNT = 32,
    parameter int          SPR_COUNT = 2048
) (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        req_write,
    input logic [15:0] req_addr,
    input logic [15:0] req_wdata,
    input logic        rsp_valid,
    input logic        rsp_ready,
    input logic        rsp_error,
    input logic [15:0] rsp_rdata,
    input logic        du_stb,
    input logic        du_we,
    input logic [15:0] du_addr,
    input logic [31:0] du_wdata,
    input logic        du_ack
);
    localparam logic [16:0] LIMIT = 17'({1'b0, WIN_BASE}) + 17'(2 * (GPR_COUNT + SPR_COUNT));

    logic acc;
    logic in_win;

    // Handshake and window membership as seen at the request port.
    always_comb begin
        acc    = req_valid && req_ready;
        in_win = (req_addr >= WIN_BASE) && ({1'b0, req_addr} < LIMIT);
    end

    a_r1_error_no_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        acc && !in_win |=> rsp_valid && rsp_error && (rsp_rdata == 16'h0) && !du_stb);

    a_r3_read_we_low: assert property (@(posedge clk) disable iff (!rst_n)
        acc && in_win && !req_write |=> du_stb && !du_we);

    a_r4_low_write_no_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        acc && in_win && req_write && !req_addr[0] |=> !du_stb && rsp_valid && !rsp_error);

    a_r5_high_write_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        acc && in_win && req_write && req_addr[0]
        |=> du_stb && du_we && (du_wdata[31:16] == $past(req_wdata)));

    a_r6_hold_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        du_stb && !du_ack |=> du_stb && $stable(du_addr) && $stable(du_we) && $stable(du_wdata));

    a_r7_hold_response: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_error) && $stable(rsp_rdata));

    a_r7_ack_gives_response: assert property (@(posedge clk) disable iff (!rst_n)
        du_stb && du_ack |=> rsp_valid && !rsp_error && !du_stb);

    a_r8_ready_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (du_stb || rsp_valid || !rsp_ready) |-> !req_ready);

endmodule

bind cdb_bridge cdb_checker #(
    .WIN_BASE  (WIN_BASE),
    .GPR_COUNT (GPR_COUNT),
    .SPR_COUNT (SPR_COUNT)
) u_cdb_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_error (rsp_error),
    .rsp_rdata (rsp_rdata),
    .du_stb    (du_stb),
    .du_we     (du_we),
    .du_addr   (du_addr),
    .du_wdata  (du_wdata),
    .du_ack    (du_ack)
);

// File: tb/cdb_bridge_test.sv
// Bench for cdb_bridge: a vector table walked by one loop, then directed tests.
module cdb_bridge_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic        rsp_error;
    logic [15:0] rsp_rdata;
    logic        du_stb;
    logic        du_we;
    logic [15:0] du_addr;
    logic [31:0] du_wdata;
    logic [31:0] du_rdata = '0;
    logic        du_ack = 1'b0;

    int checks = 0;
    int failures = 0;
    int ack_delay = 1;
    int wait_cnt = 0;
    int bus_count = 0;
    logic [15:0] last_addr = '0;
    logic        last_we = 1'b0;
    logic [31:0] last_wdata = '0;
    logic [31:0] core_mem [int];
    logic [31:0] shadow [int];
    logic [15:0] staged_model = '0;

    always #2 clk = ~clk;

    cdb_bridge uut (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_ready (req_ready), .req_write (req_write),
        .req_addr (req_addr), .req_wdata (req_wdata),
        .rsp_valid (rsp_valid), .rsp_ready (rsp_ready), .rsp_error (rsp_error),
        .rsp_rdata (rsp_rdata),
        .du_stb (du_stb), .du_we (du_we), .du_addr (du_addr), .du_wdata (du_wdata),
        .du_rdata (du_rdata), .du_ack (du_ack)
    );

    // Default content of a core register that was never written.
    function automatic logic [31:0] pattern(input logic [15:0] a);
        return {a ^ 16'hA5C3, ~a};
    endfunction

    // Core stub: acknowledge after ack_delay cycles, store writes, return data.
    always @(posedge clk) begin
        if (!rst_n) begin
            du_ack <= 1'b0;
            wait_cnt <= 0;
        end else if (du_stb && !du_ack) begin
            if (wait_cnt >= ack_delay) begin
                du_ack <= 1'b1;
                wait_cnt <= 0;
                bus_count <= bus_count + 1;
                last_addr <= du_addr;
                last_we <= du_we;
                last_wdata <= du_wdata;
                if (du_we) core_mem[int'(du_addr)] = du_wdata;
                du_rdata <= core_mem.exists(int'(du_addr)) ? core_mem[int'(du_addr)] : pattern(du_addr);
            end else begin
                wait_cnt <= wait_cnt + 1;
            end
        end else begin
            du_ack <= 1'b0;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Window membership per R1.
    function automatic bit in_win(input logic [15:0] a);
        return (a >= 16'h0200) && (((a - 16'h0200) >> 1) < 16'd2080);
    endfunction

    // Core address per R2.
    function automatic logic [15:0] map_addr(input logic [15:0] a);
        logic [15:0] idx;
        idx = (a - 16'h0200) >> 1;
        return (idx < 16'd32) ? (16'h0400 + idx) : (idx - 16'd32);
    endfunction

    function automatic logic [31:0] model_read(input logic [15:0] ca);
        return shadow.exists(int'(ca)) ? shadow[int'(ca)] : pattern(ca);
    endfunction

    // One request with rsp_ready held high; returns response and cycle count.
    task automatic do_req(input logic wr, input logic [15:0] a, input logic [15:0] d,
                          output logic err, output logic [15:0] q, output int cyc);
        int c0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        c0 = bus_count;
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_valid) @(negedge clk);
        err = rsp_error; q = rsp_rdata;
        cyc = bus_count - c0;
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        staged_model = '0;
    endtask

    // Vector table: {write, address, write data}.
    localparam int NV = 22;
    localparam logic [32:0] VEC [NV] = '{
        {1'b0, 16'h0200, 16'h0000},  // GPR0 low
        {1'b0, 16'h0201, 16'h0000},  // GPR0 high
        {1'b0, 16'h023F, 16'h0000},  // GPR31 high
        {1'b0, 16'h0240, 16'h0000},  // first SPR low
        {1'b0, 16'h0243, 16'h0000},  // SPR1 high
        {1'b0, 16'h123F, 16'h0000},  // last mapped register high
        {1'b0, 16'h1240, 16'h0000},  // one past top
        {1'b0, 16'h01FF, 16'h0000},  // just below base
        {1'b0, 16'h0000, 16'h0000},
        {1'b0, 16'hFFFF, 16'h0000},
        {1'b1, 16'h0204, 16'hBEEF},  // stage low
        {1'b1, 16'h0205, 16'hDEAD},  // commit GPR2
        {1'b0, 16'h0204, 16'h0000},
        {1'b0, 16'h0205, 16'h0000},
        {1'b1, 16'h01F0, 16'h1111},  // error write, no staging
        {1'b1, 16'h1240, 16'h2222},  // error low write, no staging
        {1'b1, 16'h0301, 16'h1234},  // commit SPR96 with staged BEEF
        {1'b0, 16'h0300, 16'h0000},
        {1'b0, 16'h0301, 16'h0000},
        {1'b1, 16'h0300, 16'h5555},  // lone low write
        {1'b0, 16'h0300, 16'h0000},  // still BEEF
        {1'b1, 16'h1238, 16'hABCD}   // low write near top
    };

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        logic err;
        logic [15:0] q;
        int cyc;
        logic [15:0] held_addr;
        logic [15:0] held_data;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 / R8: state after reset.
        check("R10 rsp_valid after reset", {31'b0, rsp_valid}, 32'd0);
        check("R10 du_stb after reset", {31'b0, du_stb}, 32'd0);
        check("R8 req_ready idle", {31'b0, req_ready}, 32'd1);
        rsp_ready = 1'b0;
        #1;
        check("R8 req_ready with rsp_ready low", {31'b0, req_ready}, 32'd0);
        rsp_ready = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic        wr;
            logic [15:0] a;
            logic [15:0] d;
            logic [31:0] word;
            wr = VEC[i][32]; a = VEC[i][31:16]; d = VEC[i][15:0];
            do_req(wr, a, d, err, q, cyc);
            if (!in_win(a)) begin
                check("R1 error flag", {31'b0, err}, 32'd1);
                check("R1 error data", {16'b0, q}, 32'd0);
                check("R1 no bus cycle", cyc, 0);
            end else if (!wr) begin
                word = model_read(map_addr(a));
                check("R3 read data", {16'b0, q}, {16'b0, a[0] ? word[31:16] : word[15:0]});
                check("R3 read ok", {31'b0, err}, 32'd0);
                check("R3 one cycle per half", cyc, 1);
                check("R2 core address", {16'b0, last_addr}, {16'b0, map_addr(a)});
                check("R3 we low", {31'b0, last_we}, 32'd0);
            end else if (!a[0]) begin
                staged_model = d;
                check("R4 no bus cycle", cyc, 0);
                check("R4 ok response", {15'b0, err, q}, 32'd0);
            end else begin
                shadow[int'(map_addr(a))] = {d, staged_model};
                check("R5 one bus cycle", cyc, 1);
                check("R5 we high", {31'b0, last_we}, 32'd1);
                check("R5 joined word", last_wdata, {d, staged_model});
                check("R2 write address", {16'b0, last_addr}, {16'b0, map_addr(a)});
                check("R5 ok response", {15'b0, err, q}, 32'd0);
            end
        end

        // R6 / R8 / R7: slow acknowledge and stalled consumer.
        ack_delay = 4;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h0202; req_wdata = '0;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        rsp_ready = 1'b0;
        held_addr = du_addr;
        check("R6 cycle open", {31'b0, du_stb}, 32'd1);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R6 address held", {16'b0, du_addr}, {16'b0, held_addr});
            check("R8 busy not ready", {31'b0, req_ready}, 32'd0);
        end
        while (!rsp_valid) @(negedge clk);
        held_data = rsp_rdata;
        check("R3 slow read data", {16'b0, held_data}, {16'b0, model_read(16'h0401) & 32'hFFFF});
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R7 response held", {15'b0, rsp_valid, rsp_rdata}, {15'b0, 1'b1, held_data});
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        check("R7 single response", {31'b0, rsp_valid}, 32'd0);
        ack_delay = 1;

        // R9: reset clears staging, so an upper-only write commits a zero low half.
        do_reset();
        @(negedge clk);
        check("R10 rsp_valid after second reset", {31'b0, rsp_valid}, 32'd0);
        do_req(1'b1, 16'h0207, 16'h7777, err, q, cyc);
        shadow[int'(16'h0403)] = 32'h7777_0000;
        check("R9 staged cleared in write", last_wdata, 32'h7777_0000);
        do_req(1'b0, 16'h0206, 16'h0000, err, q, cyc);
        check("R9 low half reads zero", {16'b0, q}, 32'd0);
        do_req(1'b0, 16'h0207, 16'h0000, err, q, cyc);
        check("R9 high half", {16'b0, q}, 32'h7777);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule